// File: doc/BRIEF.md
# Packed-Pixel Binary Threshold Unit

This block turns grayscale pixels into a two-level image. Each 32-bit input word packs four 8-bit pixels. Every pixel is compared against one programmable 8-bit threshold by subtracting the pixel from the threshold in its own 8-bit lane. The borrow out of each lane becomes a one-bit flag. The flag then selects either an all-ones byte (255) or an all-zeros byte (0) for that lane's output pixel.

Words arrive on a valid/ready stream and leave on a second valid/ready stream. Each word takes a two-step schedule. The cycle in which a word is accepted performs the packed subtraction and captures the four flags. The following cycle widens the flags into byte masks and presents the result. While the result is on offer, no new word is taken. The unit therefore delivers four pixels every two cycles when the consumer never stalls. The threshold register can be written only while no word is in flight. A word that has been accepted always completes with the threshold it was accepted with.

The controller has two states. `ST_IDLE` accepts a word and allows threshold writes. `ST_SELECT` holds the result. There are three transitions. ACCEPT goes from `ST_IDLE` to `ST_SELECT` on `in_valid` while ready. DRAIN goes from `ST_SELECT` to `ST_IDLE` when `out_ready` is high. STALL keeps `ST_SELECT` while `out_ready` is low.

Top module: `pxthr_unit`

## Requirements
- R1: Output lane i (bits [8i+7:8i]) is 8'hFF when input pixel i is strictly greater than the threshold, and 8'h00 otherwise.
- R2: Byte order is preserved: input lane 0 in bits [7:0] maps to output bits [7:0], and so on up to lane 3 in bits [31:24].
- R3: A word accepted at a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high right after that edge.
- R4: `in_ready` is low while `out_valid` is high. With `out_ready` held high, back-to-back words are accepted every second cycle, which gives four pixels per two cycles.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R6: A threshold write (`thr_we` high) while `in_ready` is high loads `thr_wdata`. Every word accepted afterwards uses the new value.
- R7: A threshold write while `in_ready` is low is ignored. Later words still use the previous threshold.
- R8: A threshold write in the same cycle as an accept does not affect that word, which uses the old threshold. The write takes effect for the next word.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, and the threshold is 128.
- R10: A pixel equal to the threshold gives 8'h00. With threshold 255 every pixel gives 8'h00. With threshold 0 only pixel value 0 gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold write value |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Unit can take a word |
| in_data | input | 32 | Four packed input pixels, lane 0 in [7:0] |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Four packed binary pixels |

## Verification
Two cases are hard to reach from the ports. The first is a threshold write that lands exactly on the accept edge. The second is a write that arrives while a result is stalled. The bench drives the write strobe together with `in_valid` on one cycle, and then again in the first cycle of `ST_SELECT`. It then checks the next word against a reference model, which shows which threshold value actually took effect. Stalls are created by a monitor that drops `out_ready` at random, so the hold behaviour is exercised over many random words and threshold reloads.

// File: rtl/pxthr_pkg.sv
package pxthr_pkg;

    // Controller states: accept/subtract, then select/present.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SELECT = 1'b1
    } pxthr_state_e;

endpackage

// File: rtl/pxthr_lane_sub.sv
module pxthr_lane_sub #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic [PIX_W-1:0] thr_i,
    output logic             borrow_o
);
    localparam int DW = PIX_W + 1;

    logic [DW-1:0] diff;

    // threshold minus pixel, one guard bit catches the borrow
    assign diff     = {1'b0, thr_i} - {1'b0, pix_i};
    assign borrow_o = |(diff >> PIX_W);

endmodule

// File: rtl/pxthr_mask_sel.sv
module pxthr_mask_sel #(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input  logic [LANES-1:0]       flag_i,
    output logic [LANES*PIX_W-1:0] word_o
);
    localparam logic [PIX_W-1:0] PIX_HI = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0] PIX_LO = {PIX_W{1'b0}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*PIX_W +: PIX_W] = flag_i[g] ? PIX_HI : PIX_LO;
    end

endmodule

// File: rtl/pxthr_ctrl.sv
module pxthr_ctrl
    import pxthr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic accept
);
    pxthr_state_e state_q;
    pxthr_state_e state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_SELECT;  // ACCEPT
            ST_SELECT: if (out_ready) state_d = ST_IDLE;    // DRAIN, else STALL
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready  = 1'b1;
            ST_SELECT: out_valid = 1'b1;
            default:   in_ready  = 1'b0;
        endcase
        accept = in_ready && in_valid;
    end

    AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!in_ready && out_valid)); // R4
    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R5
    AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> in_ready); // R4

endmodule

// File: rtl/pxthr_unit.sv
module pxthr_unit #(
    parameter int              LANES     = 4,
    parameter int              PIX_W     = 8,
    parameter logic [PIX_W-1:0] THR_RESET = 8'd128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   thr_we,
    input  logic [PIX_W-1:0]       thr_wdata,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*PIX_W-1:0] in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*PIX_W-1:0] out_data
);
    localparam int WORD_W = LANES * PIX_W;

    logic [PIX_W-1:0] thr_q;
    logic [LANES-1:0] borrow;
    logic [LANES-1:0] flag_q;
    logic             accept;

    pxthr_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .accept    (accept)
    );

    // threshold register: writable only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 thr_q <= THR_RESET;
        else if (thr_we && in_ready) thr_q <= thr_wdata;
    end

    // step 1: packed subtraction, one lane per pixel
    for (genvar g = 0; g < LANES; g++) begin : g_sub
        pxthr_lane_sub #(.PIX_W(PIX_W)) i_sub (
            .pix_i    (in_data[g*PIX_W +: PIX_W]),
            .thr_i    (thr_q),
            .borrow_o (borrow[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= '0;
        else if (accept) flag_q <= borrow;
    end

    // step 2: flags widened to byte masks
    pxthr_mask_sel #(.LANES(LANES), .PIX_W(PIX_W)) i_sel (
        .flag_i (flag_q),
        .word_o (out_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_LANE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> (out_data[g*PIX_W +: PIX_W] ==
                (($past(in_data[g*PIX_W +: PIX_W]) > $past(thr_q)) ?
                 {PIX_W{1'b1}} : {PIX_W{1'b0}}))); // R1
    end

    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R3
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R5
    AST_THR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(thr_q)); // R7

    logic [WORD_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: tb/test_pxthr_unit.sv
module test_pxthr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_we = 1'b0;
    logic [7:0]  thr_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [7:0]  model_thr = 8'd128;
    bit          stall_mode = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pxthr_unit i_pxthr_unit (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] ref_word(logic [31:0] w, logic [7:0] t);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = (w[i*8 +: 8] > t) ? 8'hFF : 8'h00;
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // driver: caller sits at a negedge
    task automatic send(logic [31:0] w, string tag, bit do_load = 0, logic [7:0] lv = 0);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        exp_q.push_back(ref_word(w, model_thr));
        tag_q.push_back(tag);
        if (do_load) begin
            thr_we = 1'b1; thr_wdata = lv; model_thr = lv;   // R8: takes effect next word
        end
        @(negedge clk);
        in_valid = 1'b0;
        thr_we   = 1'b0;
        check(out_valid === 1'b1, "R3", {31'b0, out_valid}, 32'd1);
        check(in_ready === 1'b0, "R4", {31'b0, in_ready}, 32'd0);
    endtask

    task automatic load_thr(logic [7:0] v);
        while (!in_ready) @(negedge clk);
        thr_we = 1'b1; thr_wdata = v; model_thr = v;          // R6
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        logic [31:0] hold_data;
        bit          hold_pend;
        hold_pend = 0;
        hold_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
                if (hold_pend)
                    check(out_valid === 1'b1 && out_data === hold_data, "R5", out_data, hold_data);
                hold_pend = out_valid && !out_ready;
                hold_data = out_data;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected output", out_data, 32'h0);
                    end else begin
                        logic [31:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_data === e, t, out_data, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_test();
    end

    initial begin
        time t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state and reset threshold 128
        check(in_ready === 1'b1, "R9", {31'b0, in_ready}, 32'd1);
        check(out_valid === 1'b0, "R9", {31'b0, out_valid}, 32'd0);
        send(32'hFF00_8180, "R9 R1 R10 threshold 128");
        // R2: distinct lane pattern keeps byte order
        load_thr(8'h10);
        send(32'h00FF_00FF, "R2 lane order");
        send(32'h11_10_0F_80, "R2 R1 mixed lanes");
        // R10: equal, threshold 0 and 255
        load_thr(8'h5A);
        send(32'h5A5A_5A5A, "R10 equal to threshold");
        send(32'h5B59_5A5B, "R10 R1 around threshold");
        load_thr(8'h00);
        send(32'h0001_00FF, "R10 threshold 0");
        load_thr(8'hFF);
        send(32'hFFFE_0080, "R10 threshold 255");
        // R8: load on the accept edge
        load_thr(8'h40);
        send(32'h4130_7F20, "R8 word uses old threshold", 1'b1, 8'hC0);
        send(32'hC1C0_BF41, "R8 R6 next word uses new threshold");
        // R7: write while busy is dropped
        send(32'h1234_5678, "R7 before busy write");
        thr_we = 1'b1; thr_wdata = 8'h00;
        @(negedge clk);
        thr_we = 1'b0;
        send(32'h01C1_C0FF, "R7 busy write ignored");
        // R4: throughput with consumer always ready
        t0 = $time;
        for (int k = 0; k < 8; k++) send(32'h0102_0304 * (k + 1), "R4 back to back");
        check(($time - t0) == 16 * CLK_PERIOD, "R4 throughput", 32'($time - t0), 32'(16 * CLK_PERIOD));
        // random words with stalls and reloads
        stall_mode = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (k % 25 == 0) load_thr(8'($urandom));
            send($urandom, "R1 R5 random");
        end
        while (exp_q.size() != 0) @(negedge clk);
        done = 1'b1;
        finish_test();
    end

endmodule